// File: doc/BRIEF.md
# Dual-Bank Vectored Interrupt Prioritizer

This block merges two banks of 32 interrupt sources into one prioritized request for a processor. Each source is pending when its raw line is high and its enable bit is set. Each bank also has a table of sixteen programmable vectored slots. A slot names one source of its bank, and the slot only counts when the slot enable is set. Among all pending sources there is one winner, and the block encodes it as an 11-bit vector word that software reads to find the source to service.

Priority is fixed and runs across both banks. First come the bank-1 vectored slots, then the bank-2 vectored slots. After them come the plain pending sources of bank 1, and last those of bank 2. In the word, one of three flag bits marks the kind of winner, and the low six bits carry the global source number: bank-1 sources are 0 to 31 and bank-2 sources are 32 to 63. Because of the flag bits, a nonzero word is never confused with "nothing pending", even for source 0. Software programs the enables and slots through a simple synchronous register port. The vector word can be read back at two addresses, one for each bank, and both return the same shared result.

Top module: `dual_bank_vic`

## Requirements
- R1: A synchronous active-high `rst` clears both enable registers and every slot entry. In the cycle after reset, `irq` is 0, `vec_word` is 0x000 and every register reads as 0.
- R2: A source is pending only when both its raw bit and its enable bit are 1. Raw bits whose enable is 0 leave `irq` at 0 and `vec_word` at 0x000.
- R3: `irq` and `vec_word` are registered. A change at the inputs shows after the next rising clock edge, and `irq` is 1 exactly when `vec_word` is nonzero.
- R4: When the winner is a vectored slot, the word is 0x100 OR the global source number. Source 0 therefore gives 0x100.
- R5: All bank-1 vectored slots outrank all bank-2 vectored slots. Within a bank, the lower slot index wins. A slot counts only if its source is pending.
- R6: A vectored winner beats every non-vectored pending source, whatever bank that source is on.
- R7: With no vectored winner, the lowest-numbered pending bank-1 source wins, and the word is 0x200 OR its number.
- R8: With no vectored winner and nothing pending in bank 1, the lowest pending bank-2 source wins, and the word is 0x400 OR (32 + its index).
- R9: Reads at address 0x02 and at address 0x03 both return the same current vector word, zero-extended.
- R10: The register map is as follows. Address 0x00 holds the bank-1 enables and 0x01 holds the bank-2 enables. Addresses 0x20+n hold bank-1 slot n, and 0x30+n hold bank-2 slot n. In a slot entry, bit 5 is the slot enable and bits 4:0 are the source index. `rdata` is valid one cycle after `addr` is presented.
- R11: A slot whose enable bit is 0 is ignored, so its source is reported as a non-vectored source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_b1 | input | 32 | Raw interrupt lines of bank 1 |
| raw_b2 | input | 32 | Raw interrupt lines of bank 2 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address for write and read |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request to the processor |
| vec_word | output | 11 | Encoded winner: flag bits 10:8, source number 5:0 |

## Verification
The assertions assume that the raw lines and the register port are driven synchronously to `clk` with defined values, and that `rst` is high at the first clock edge. The bench meets this by changing every input only at falling edges and by holding reset for several cycles at the start. The assertions also assume that reads and writes never arrive in the same cycle. The bench never asserts `wr_en` while it reads, so that a read's one-cycle latency is not mixed with a table update.

// File: rtl/vic_pkg.sv
package vic_pkg;

  localparam int VEC_W    = 11;
  localparam int GID_W    = 6;
  localparam int FLAG_VEC = 8;
  localparam int FLAG_B1  = 9;
  localparam int FLAG_B2  = 10;

  typedef logic [VEC_W-1:0] vec_word_t;
  typedef logic [GID_W-1:0] gid_t;

  // word for a vectored slot winner
  function automatic vec_word_t vw_vectored(input gid_t gid);
    vec_word_t w;
    w = '0;
    w[FLAG_VEC] = 1'b1;
    w[GID_W-1:0] = gid;
    return w;
  endfunction

  // word for a plain (non-vectored) winner; second_bank selects the flag
  function automatic vec_word_t vw_plain(input logic second_bank, input gid_t gid);
    vec_word_t w;
    w = '0;
    if (second_bank) w[FLAG_B2] = 1'b1;
    else             w[FLAG_B1] = 1'b1;
    w[GID_W-1:0] = gid;
    return w;
  endfunction

endpackage

// File: rtl/vic_bank.sv
module vic_bank #(
  parameter int SRC_N  = 32,
  parameter int SLOT_N = 16,
  localparam int IDX_W  = $clog2(SRC_N),
  localparam int SLOT_W = $clog2(SLOT_N),
  localparam int ENT_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  raw,
  input  logic              en_we,
  input  logic [SRC_N-1:0]  en_wdata,
  input  logic              slot_we,
  input  logic [SLOT_W-1:0] slot_wsel,
  input  logic [ENT_W-1:0]  slot_wdata,
  input  logic [SLOT_W-1:0] slot_rsel,
  output logic [SRC_N-1:0]  en_q,
  output logic [ENT_W-1:0]  slot_rdata,
  output logic [SRC_N-1:0]  pending,
  output logic              vec_hit,
  output logic [IDX_W-1:0]  vec_src,
  output logic              dflt_hit,
  output logic [IDX_W-1:0]  dflt_src
);

  logic [ENT_W-1:0] slot_q [SLOT_N];

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
      for (int s = 0; s < SLOT_N; s++) slot_q[s] <= '0;
    end else begin
      if (en_we)   en_q <= en_wdata;
      if (slot_we) slot_q[slot_wsel] <= slot_wdata;
    end
  end

  assign slot_rdata = slot_q[slot_rsel];
  assign pending    = raw & en_q;

  // slot scan: walk downward so the lowest live slot is left standing
  always_comb begin
    vec_hit = 1'b0;
    vec_src = '0;
    for (int s = SLOT_N - 1; s >= 0; s--) begin
      if (slot_q[s][IDX_W] && pending[slot_q[s][IDX_W-1:0]]) begin
        vec_hit = 1'b1;
        vec_src = slot_q[s][IDX_W-1:0];
      end
    end
  end

  // plain scan: lowest pending source
  always_comb begin
    dflt_hit = 1'b0;
    dflt_src = '0;
    for (int i = SRC_N - 1; i >= 0; i--) begin
      if (pending[i]) begin
        dflt_hit = 1'b1;
        dflt_src = IDX_W'(i);
      end
    end
  end

  // R5
  vec_src_pending_chk: assert property (@(posedge clk) disable iff (rst)
    vec_hit |-> pending[vec_src]);

  // R7
  dflt_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    dflt_hit |-> (pending[dflt_src] &&
                  ((pending & ~({SRC_N{1'b1}} << dflt_src)) == '0)));

  // R2
  dflt_none_chk: assert property (@(posedge clk) disable iff (rst)
    (pending == '0) |-> (!dflt_hit && !vec_hit));

endmodule

// File: rtl/vic_merge.sv
module vic_merge
  import vic_pkg::*;
#(
  parameter int SRC_N = 32,
  localparam int IDX_W = $clog2(SRC_N)
) (
  input  logic             vec_hit  [2],
  input  logic [IDX_W-1:0] vec_src  [2],
  input  logic             dflt_hit [2],
  input  logic [IDX_W-1:0] dflt_src [2],
  output vec_word_t        word
);

  function automatic gid_t to_gid(input logic second_bank, input logic [IDX_W-1:0] src);
    return GID_W'(second_bank ? SRC_N + int'(src) : int'(src));
  endfunction

  always_comb begin
    if (vec_hit[0])       word = vw_vectored(to_gid(1'b0, vec_src[0]));
    else if (vec_hit[1])  word = vw_vectored(to_gid(1'b1, vec_src[1]));
    else if (dflt_hit[0]) word = vw_plain(1'b0, to_gid(1'b0, dflt_src[0]));
    else if (dflt_hit[1]) word = vw_plain(1'b1, to_gid(1'b1, dflt_src[1]));
    else                  word = '0;
  end

endmodule

// File: rtl/dual_bank_vic.sv
module dual_bank_vic
  import vic_pkg::*;
#(
  parameter int SRC_N  = 32,
  parameter int SLOT_N = 16,
  localparam int IDX_W  = $clog2(SRC_N),
  localparam int SLOT_W = $clog2(SLOT_N),
  localparam int ENT_W  = IDX_W + 1,
  localparam int ADDR_W = SLOT_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_N-1:0]  raw_b1,
  input  logic [SRC_N-1:0]  raw_b2,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [SRC_N-1:0]  wdata,
  output logic [SRC_N-1:0]  rdata,
  output logic              irq,
  output logic [VEC_W-1:0]  vec_word
);

  logic [SRC_N-1:0] raw_a   [2];
  logic [SRC_N-1:0] en_a    [2];
  logic [SRC_N-1:0] pend_a  [2];
  logic [ENT_W-1:0] slot_rd [2];
  logic             vec_hit [2];
  logic [IDX_W-1:0] vec_src [2];
  logic             dflt_hit[2];
  logic [IDX_W-1:0] dflt_src[2];

  logic       slot_region;
  logic       any_pending;
  vec_word_t  win_word;
  vec_word_t  vec_q;
  logic       irq_q;
  logic [SRC_N-1:0] rd_next;
  logic [SRC_N-1:0] rdata_q;
  logic unused_wdata;

  assign raw_a[0]     = raw_b1;
  assign raw_a[1]     = raw_b2;
  assign slot_region  = addr[ADDR_W-1];
  assign unused_wdata = &{1'b0, wdata[SRC_N-1:ENT_W]};

  for (genvar b = 0; b < 2; b++) begin : g_bank
    vic_bank #(.SRC_N(SRC_N), .SLOT_N(SLOT_N)) u_bank (
      .clk        (clk),
      .rst        (rst),
      .raw        (raw_a[b]),
      .en_we      (wr_en && !slot_region && (addr[1:0] == 2'(b))),
      .en_wdata   (wdata),
      .slot_we    (wr_en && slot_region && (addr[SLOT_W] == 1'(b))),
      .slot_wsel  (addr[SLOT_W-1:0]),
      .slot_wdata (wdata[ENT_W-1:0]),
      .slot_rsel  (addr[SLOT_W-1:0]),
      .en_q       (en_a[b]),
      .slot_rdata (slot_rd[b]),
      .pending    (pend_a[b]),
      .vec_hit    (vec_hit[b]),
      .vec_src    (vec_src[b]),
      .dflt_hit   (dflt_hit[b]),
      .dflt_src   (dflt_src[b])
    );
  end

  vic_merge #(.SRC_N(SRC_N)) u_merge (
    .vec_hit  (vec_hit),
    .vec_src  (vec_src),
    .dflt_hit (dflt_hit),
    .dflt_src (dflt_src),
    .word     (win_word)
  );

  assign any_pending = (|pend_a[0]) || (|pend_a[1]);

  always_comb begin
    rd_next = '0;
    if (slot_region) begin
      rd_next[ENT_W-1:0] = slot_rd[addr[SLOT_W]];
    end else begin
      case (addr[1:0])
        2'd0:    rd_next = en_a[0];
        2'd1:    rd_next = en_a[1];
        default: rd_next[VEC_W-1:0] = vec_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q   <= '0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      vec_q   <= win_word;
      irq_q   <= any_pending;
      rdata_q <= rd_next;
    end
  end

  assign vec_word = vec_q;
  assign irq      = irq_q;
  assign rdata    = rdata_q;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (vec_q == '0 && !irq_q && rdata_q == '0));

  // R3
  irq_matches_word_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (vec_q != '0));

  // R3
  word_one_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(vec_q[FLAG_B2:FLAG_VEC]));

  // R6
  vectored_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_hit[0] || vec_hit[1]) |=> vec_q[FLAG_VEC]);

  // R5
  bank2_vec_id_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_hit[1] && !vec_hit[0]) |=> (vec_q[FLAG_VEC] && vec_q[IDX_W]));

  // R8
  bank2_plain_chk: assert property (@(posedge clk) disable iff (rst)
    (!vec_hit[0] && !vec_hit[1] && !dflt_hit[0] && dflt_hit[1]) |=> vec_q[FLAG_B2]);

endmodule

// File: tb/dual_bank_vic_tb.sv
module dual_bank_vic_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] raw_b1 = '0;
  logic [31:0] raw_b2 = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [10:0] vec_word;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dual_bank_vic u_dut (
    .clk(clk), .rst(rst), .raw_b1(raw_b1), .raw_b2(raw_b2),
    .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq), .vec_word(vec_word)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic expect_word(input string req, input logic [10:0] exp);
    check(req, {31'd0, irq}, {31'd0, exp != 11'd0});
    check(req, {21'd0, vec_word}, {21'd0, exp});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    expect_word("R1 out after reset", 11'h000);
    rd(6'h00, d); check("R1 en1 cleared", d, 32'h0);
    rd(6'h3F, d); check("R1 slot cleared", d, 32'h0);
  endtask

  task automatic t_mask();
    @(negedge clk);
    raw_b1 = '1; raw_b2 = '1;
    settle(); settle();
    expect_word("R2 masked raw ignored", 11'h000);
    @(negedge clk);
    raw_b1 = '0; raw_b2 = '0;
  endtask

  task automatic t_plain();
    wr(6'h00, (32'd1 << 3) | (32'd1 << 9));
    settle();
    raw_b1 = 32'd1 << 9;
    check("R3 irq before edge", {31'd0, irq}, 32'd0);
    settle();
    expect_word("R7 single bank1 plain", 11'h209);
    raw_b1 = (32'd1 << 9) | (32'd1 << 3);
    settle();
    expect_word("R7 lowest bank1 plain", 11'h203);
    wr(6'h01, 32'd1 << 4);
    raw_b2 = 32'd1 << 4;
    settle();
    expect_word("R8 bank1 plain beats bank2", 11'h203);
    raw_b1 = '0;
    settle();
    expect_word("R8 bank2 plain", 11'h424);
    raw_b2 = '0;
    settle();
    expect_word("R3 irq drops", 11'h000);
  endtask

  task automatic t_vectored();
    wr(6'h00, 32'h0000_0209);
    wr(6'h25, 32'h20);
    raw_b1 = 32'd1;
    settle();
    expect_word("R4 source zero vectored", 11'h100);
    wr(6'h22, 32'h29);
    raw_b1 = 32'h0000_0201;
    settle();
    expect_word("R5 lower slot wins", 11'h109);
    wr(6'h30, 32'h24);
    raw_b2 = 32'd1 << 4;
    settle();
    expect_word("R5 bank1 slot beats bank2 slot", 11'h109);
    raw_b1 = 32'd1 << 3;
    settle();
    expect_word("R6 bank2 vectored beats bank1 plain", 11'h124);
  endtask

  task automatic t_slot_off();
    wr(6'h30, 32'h04);
    settle();
    expect_word("R11 disabled slot ignored", 11'h203);
    raw_b1 = '0;
    settle();
    expect_word("R11 source falls to plain", 11'h424);
  endtask

  task automatic t_readback();
    logic [31:0] d;
    rd(6'h02, d); check("R9 view bank1", d, 32'h424);
    rd(6'h03, d); check("R9 view bank2", d, 32'h424);
    rd(6'h22, d); check("R10 slot entry b1", d, 32'h29);
    rd(6'h30, d); check("R10 slot entry b2", d, 32'h04);
    rd(6'h00, d); check("R10 enable b1", d, 32'h209);
    rd(6'h01, d); check("R10 enable b2", d, 32'h10);
  endtask

  task automatic t_reset_again();
    logic [31:0] d;
    @(negedge clk);
    rst = 1'b1;
    settle();
    rst = 1'b0;
    raw_b1 = 32'h0000_0209;
    settle();
    expect_word("R1 enables gone after reset", 11'h000);
    rd(6'h22, d); check("R1 slot gone", d, 32'h0);
    rd(6'h01, d); check("R1 en2 gone", d, 32'h0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_mask();
    t_plain();
    t_vectored();
    t_slot_off();
    t_readback();
    t_reset_again();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule